// File: doc/BRIEF.md
# Dual-Control Six-Bit Sequence Counter

This block is a small binary counter that serves as the timing backbone of a sequence or waveform generator. On every active clock edge it either advances by one, stays where it is, or returns to zero. Which of the three happens depends on a clear control and a hold control. Each control has two sources, and the two sources are ORed together.

The first source of each control is a direct request bit that acts on the same edge. The second source is the output of a set/reset state register. That register is loaded by its own pair of set and reset request bits, so it acts one edge after the request. The request bits come from product-term logic outside this block and arrive as plain input bits.

A parameter chooses whether the rising or the falling clock edge is active. A synchronous initialisation input puts the count and both state registers into a known zero state, which is needed because nothing defines the power-up state. When a state register sees set and reset together, it keeps its value and raises a sticky conflict flag.

Top module: `seq_counter_dual`

## Requirements
- R1: With `init` high at an active edge, after that edge `count` is 0, `clr_held` is 0, `hold_held` is 0 and `sr_conflict` is 0.
- R2: With no clear and no hold active, `count` increases by one on each active edge, and 63 is followed by 0.
- R3: If `clr_now` or `clr_held` is 1 at an active edge, `count` is 0 after that edge.
- R4: If `hold_now` or `hold_held` is 1 and neither clear source is 1 at an active edge, `count` keeps its value across that edge.
- R5: When a clear source and a hold source are both 1 at an edge, the clear takes effect and `count` becomes 0.
- R6: Each state register (`clr_held` driven by `clr_set`/`clr_reset`, `hold_held` driven by `hold_set`/`hold_reset`) takes the value 1 after an edge with set=1 and reset=0. It takes 0 after an edge with set=0 and reset=1, and keeps its value when both are 0. The new value affects the count from the following edge onward.
- R7: When set and reset of either state register are both 1 at an edge, that register keeps its value and `sr_conflict` becomes 1. The flag stays 1 until `init`.
- R8: Parameter `FALL_EDGE` = 0 (default) makes the rising edge of `clk` active. `FALL_EDGE` = 1 makes the falling edge active, and the rising edge then changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; active edge chosen by `FALL_EDGE` |
| init | input | 1 | Synchronous active-high initialisation |
| clr_now | input | 1 | Direct clear request |
| hold_now | input | 1 | Direct hold request |
| clr_set | input | 1 | Set term of the clear state register |
| clr_reset | input | 1 | Reset term of the clear state register |
| hold_set | input | 1 | Set term of the hold state register |
| hold_reset | input | 1 | Reset term of the hold state register |
| count | output | 6 | Counter value |
| clr_held | output | 1 | Clear state register output |
| hold_held | output | 1 | Hold state register output |
| sr_conflict | output | 1 | Sticky flag: set and reset seen together |

## Verification
Direct clear and hold requests change `count` one active edge after they are applied. A set or reset request appears on `clr_held`/`hold_held` after one edge, but reaches `count` only after two edges, because the latched control first has to be registered. The conflict flag rises one edge after the colliding terms. The bench applies inputs just after the inactive edge and compares every output there against a model that is advanced by exactly one edge per applied input set, so each result is sampled in the cycle it is due. The falling-edge variant is sampled shortly after each edge of both kinds, which shows that only the chosen edge moves the count.

// File: rtl/seq_counter_pkg.sv
package seq_counter_pkg;

    localparam int CNT_W    = 6;
    localparam int NUM_CTRL = 2;
    localparam int IDX_CLR  = 0;
    localparam int IDX_HOLD = 1;

    typedef enum logic [1:0] {
        ACT_ADVANCE = 2'd0,
        ACT_KEEP    = 2'd1,
        ACT_ZERO    = 2'd2
    } cnt_action_e;

    typedef struct packed {
        logic set;
        logic rst;
    } sr_req_t;

    typedef struct packed {
        logic clr;
        logic hold;
    } ctrl_pair_t;

    // Clear outranks hold; only when neither is present does the count move.
    function automatic cnt_action_e pick_action(input ctrl_pair_t c);
        if (c.clr)       return ACT_ZERO;
        else if (c.hold) return ACT_KEEP;
        else             return ACT_ADVANCE;
    endfunction

    // Next value of a set/reset cell; a collision keeps the old value.
    function automatic logic sr_next(input logic q, input sr_req_t r);
        case ({r.set, r.rst})
            2'b10:   return 1'b1;
            2'b01:   return 1'b0;
            default: return q;
        endcase
    endfunction

endpackage

// File: rtl/seq_sr_cell.sv
module seq_sr_cell
    import seq_counter_pkg::*;
(
    input  logic    clk,
    input  logic    init,
    input  sr_req_t req,
    output logic    q,
    output logic    collide
);

    always_ff @(posedge clk) begin
        if (init) begin
            q <= 1'b0;
        end else begin
            q <= sr_next(q, req);
        end
    end

    assign collide = req.set & req.rst;

endmodule

// File: rtl/seq_ctrl_merge.sv
module seq_ctrl_merge
    import seq_counter_pkg::*;
(
    input  ctrl_pair_t  direct,
    input  ctrl_pair_t  latched,
    output cnt_action_e action
);

    ctrl_pair_t merged;

    always_comb begin
        merged.clr  = direct.clr  | latched.clr;
        merged.hold = direct.hold | latched.hold;
        action      = pick_action(merged);
    end

endmodule

// File: rtl/seq_cnt_core.sv
module seq_cnt_core
    import seq_counter_pkg::*;
#(
    parameter int WIDTH = CNT_W
) (
    input  logic             clk,
    input  logic             init,
    input  cnt_action_e      action,
    output logic [WIDTH-1:0] value
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] nxt;

    always_comb begin
        unique case (action)
            ACT_ZERO:    nxt = '0;
            ACT_KEEP:    nxt = value;
            ACT_ADVANCE: nxt = value + ONE;
            default:     nxt = value;
        endcase
    end

    always_ff @(posedge clk) begin
        if (init) value <= '0;
        else      value <= nxt;
    end

endmodule

// File: rtl/seq_counter_dual.sv
module seq_counter_dual
    import seq_counter_pkg::*;
#(
    parameter bit FALL_EDGE = 1'b0
) (
    input  logic             clk,
    input  logic             init,
    input  logic             clr_now,
    input  logic             hold_now,
    input  logic             clr_set,
    input  logic             clr_reset,
    input  logic             hold_set,
    input  logic             hold_reset,
    output logic [CNT_W-1:0] count,
    output logic             clr_held,
    output logic             hold_held,
    output logic             sr_conflict
);

    logic                act_clk;
    sr_req_t             reqs    [NUM_CTRL];
    logic [NUM_CTRL-1:0] held_q;
    logic [NUM_CTRL-1:0] collide;
    ctrl_pair_t          direct_c;
    ctrl_pair_t          latched_c;
    cnt_action_e         action;
    logic                conflict_q;

    generate
        if (FALL_EDGE) begin : g_fall
            assign act_clk = ~clk;
        end else begin : g_rise
            assign act_clk = clk;
        end
    endgenerate

    assign reqs[IDX_CLR]  = '{set: clr_set,  rst: clr_reset};
    assign reqs[IDX_HOLD] = '{set: hold_set, rst: hold_reset};

    generate
        for (genvar i = 0; i < NUM_CTRL; i++) begin : g_sr
            seq_sr_cell u_cell (
                .clk     (act_clk),
                .init    (init),
                .req     (reqs[i]),
                .q       (held_q[i]),
                .collide (collide[i])
            );
        end
    endgenerate

    assign direct_c  = '{clr: clr_now, hold: hold_now};
    assign latched_c = '{clr: held_q[IDX_CLR], hold: held_q[IDX_HOLD]};

    seq_ctrl_merge u_merge (
        .direct  (direct_c),
        .latched (latched_c),
        .action  (action)
    );

    seq_cnt_core #(.WIDTH(CNT_W)) u_core (
        .clk    (act_clk),
        .init   (init),
        .action (action),
        .value  (count)
    );

    always_ff @(posedge act_clk) begin
        if (init)          conflict_q <= 1'b0;
        else if (|collide) conflict_q <= 1'b1;
    end

    assign clr_held    = held_q[IDX_CLR];
    assign hold_held   = held_q[IDX_HOLD];
    assign sr_conflict = conflict_q;

endmodule

// File: rtl/seq_counter_dual_chk.sv
module seq_counter_dual_chk
    import seq_counter_pkg::*;
(
    input logic             clk,
    input logic             init,
    input logic             clr_now,
    input logic             hold_now,
    input logic             clr_set,
    input logic             clr_reset,
    input logic             hold_set,
    input logic             hold_reset,
    input logic [CNT_W-1:0] count,
    input logic             clr_held,
    input logic             hold_held,
    input logic             sr_conflict
);

    AST_INIT_ZERO: assert property (@(posedge clk) init |=> (count == '0 && !clr_held && !hold_held && !sr_conflict)); // R1

    AST_ADVANCE: assert property (@(posedge clk) disable iff (init)
        (!clr_now && !clr_held && !hold_now && !hold_held) |=> count == CNT_W'($past(count) + 1'b1)); // R2

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (init)
        (clr_now || clr_held) |=> count == '0); // R3

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (init)
        (!clr_now && !clr_held && (hold_now || hold_held)) |=> $stable(count)); // R4

    AST_CLEAR_OVER_HOLD: assert property (@(posedge clk) disable iff (init)
        ((clr_now || clr_held) && (hold_now || hold_held)) |=> count == '0); // R5

    AST_CLR_SR_SET: assert property (@(posedge clk) disable iff (init)
        (clr_set && !clr_reset) |=> clr_held); // R6

    AST_HOLD_SR_RESET: assert property (@(posedge clk) disable iff (init)
        (!hold_set && hold_reset) |=> !hold_held); // R6

    AST_SR_COLLIDE_KEEP: assert property (@(posedge clk) disable iff (init)
        (clr_set && clr_reset) |=> $stable(clr_held)); // R7

    AST_CONFLICT_RISE: assert property (@(posedge clk) disable iff (init)
        ((clr_set && clr_reset) || (hold_set && hold_reset)) |=> sr_conflict); // R7

    AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (init)
        sr_conflict |=> sr_conflict); // R7

endmodule

bind seq_counter_dual seq_counter_dual_chk chk_i (
    .clk         (act_clk),
    .init        (init),
    .clr_now     (clr_now),
    .hold_now    (hold_now),
    .clr_set     (clr_set),
    .clr_reset   (clr_reset),
    .hold_set    (hold_set),
    .hold_reset  (hold_reset),
    .count       (count),
    .clr_held    (clr_held),
    .hold_held   (hold_held),
    .sr_conflict (sr_conflict)
);

// File: tb/seq_counter_dual_tb.sv
module seq_counter_dual_tb_top;

    localparam int W = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic init, clr_now, hold_now, clr_set, clr_reset, hold_set, hold_reset;
    logic [W-1:0] count;
    logic clr_held, hold_held, sr_conflict;

    logic init_f;
    logic [W-1:0] count_f;
    logic clr_held_f, hold_held_f, sr_conflict_f;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] m_cnt;
    logic m_lc, m_lh, m_conf;

    seq_counter_dual dut_i (
        .clk(clk), .init(init), .clr_now(clr_now), .hold_now(hold_now),
        .clr_set(clr_set), .clr_reset(clr_reset), .hold_set(hold_set),
        .hold_reset(hold_reset), .count(count), .clr_held(clr_held),
        .hold_held(hold_held), .sr_conflict(sr_conflict)
    );

    seq_counter_dual #(.FALL_EDGE(1'b1)) dut_fall_i (
        .clk(clk), .init(init_f), .clr_now(1'b0), .hold_now(1'b0),
        .clr_set(1'b0), .clr_reset(1'b0), .hold_set(1'b0),
        .hold_reset(1'b0), .count(count_f), .clr_held(clr_held_f),
        .hold_held(hold_held_f), .sr_conflict(sr_conflict_f)
    );

    function automatic logic sr_model(input logic q, input logic s, input logic r);
        if (s && !r) return 1'b1;
        if (!s && r) return 1'b0;
        return q;
    endfunction

    function automatic logic [W-1:0] cnt_model(input logic [W-1:0] c, input logic clr, input logic hold);
        if (clr)  return '0;
        if (hold) return c;
        return W'(c + 1);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One active edge: compare outputs of the previous edge, apply inputs, advance model.
    task automatic step(input string tag, input logic r, input logic cd, input logic hd,
                        input logic cs, input logic cr, input logic hs, input logic hr);
        @(negedge clk);
        check({tag, " count"}, 32'(count), 32'(m_cnt));
        check({tag, " clr_held"}, 32'(clr_held), 32'(m_lc));
        check({tag, " hold_held"}, 32'(hold_held), 32'(m_lh));
        check({tag, " sr_conflict"}, 32'(sr_conflict), 32'(m_conf));
        init = r; clr_now = cd; hold_now = hd;
        clr_set = cs; clr_reset = cr; hold_set = hs; hold_reset = hr;
        if (r) begin
            m_cnt = '0; m_lc = 1'b0; m_lh = 1'b0; m_conf = 1'b0;
        end else begin
            m_cnt  = cnt_model(m_cnt, cd | m_lc, hd | m_lh);
            m_conf = m_conf | (cs & cr) | (hs & hr);
            m_lc   = sr_model(m_lc, cs, cr);
            m_lh   = sr_model(m_lh, hs, hr);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] snap;
        void'($urandom(32'h5eed_0c7a));
        init = 1'b1; clr_now = 0; hold_now = 0; clr_set = 0; clr_reset = 0;
        hold_set = 0; hold_reset = 0; init_f = 1'b1;
        m_cnt = '0; m_lc = 0; m_lh = 0; m_conf = 0;
        repeat (3) @(posedge clk);

        // R1: reset state
        step("R1 init", 1, 0, 0, 0, 0, 0, 0);
        step("R1 init", 0, 0, 0, 0, 0, 0, 0);

        // R2: free run through wrap 63 -> 0
        for (int i = 0; i < 70; i++) step("R2 advance/wrap", 0, 0, 0, 0, 0, 0, 0);

        // R3: direct clear
        step("R3 direct clear", 0, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) step("R2 advance", 0, 0, 0, 0, 0, 0, 0);

        // R4: direct hold
        for (int i = 0; i < 4; i++) step("R4 direct hold", 0, 0, 1, 0, 0, 0, 0);

        // R5: clear and hold together
        step("R5 clear over hold", 0, 1, 1, 0, 0, 0, 0);
        step("R5 clear over hold", 0, 0, 0, 0, 0, 0, 0);

        // R6: latched hold, then latched clear, then release
        for (int i = 0; i < 3; i++) step("R2 advance", 0, 0, 0, 0, 0, 0, 0);
        step("R6 hold set", 0, 0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 3; i++) step("R6 hold latched", 0, 0, 0, 0, 0, 0, 0);
        step("R6 clr set", 0, 0, 0, 1, 0, 0, 0);
        for (int i = 0; i < 2; i++) step("R6/R5 latched clear", 0, 0, 0, 0, 0, 0, 0);
        step("R6 release", 0, 0, 0, 0, 1, 0, 1);
        for (int i = 0; i < 3; i++) step("R6 released", 0, 0, 0, 0, 0, 0, 0);

        // R7: collision keeps value and raises sticky flag
        step("R7 set hold", 0, 0, 0, 0, 0, 1, 0);
        step("R7 collide", 0, 0, 0, 1, 1, 1, 1);
        for (int i = 0; i < 4; i++) step("R7 sticky", 0, 0, 0, 0, 0, 0, 1);
        step("R1 init clears flag", 1, 0, 0, 0, 0, 0, 0);
        step("R1 init clears flag", 0, 0, 0, 0, 0, 0, 0);

        // Constrained random mix (R2..R7)
        for (int i = 0; i < 3000; i++) begin
            logic cs, cr, hs, hr;
            cs = ($urandom % 10) == 0; cr = ($urandom % 8) == 0;
            hs = ($urandom % 10) == 0; hr = ($urandom % 6) == 0;
            if ((i % 500) != 250) begin
                if (cs && cr) cr = 1'b0;
                if (hs && hr) hr = 1'b0;
            end
            step("R2-R7 random", ($urandom % 400) == 0, ($urandom % 16) == 0,
                 ($urandom % 6) == 0, cs, cr, hs, hr);
        end
        step("R2-R7 random tail", 0, 0, 0, 0, 0, 0, 0);

        // R8: falling-edge variant moves only on falling edges
        @(posedge clk); #1 init_f = 1'b0;
        @(negedge clk); #1 check("R8 fall after init", 32'(count_f), 32'd1);
        for (int i = 0; i < 5; i++) begin
            snap = count_f;
            @(posedge clk); #1 check("R8 rising edge no change", 32'(count_f), 32'(snap));
            @(negedge clk); #1 check("R8 falling edge advances", 32'(count_f), 32'(W'(snap + 1)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule